// File: doc/BRIEF.md
# Peripheral Reset Sequencer

This block is a small bus master that brings a peripheral back from a soft reset. The peripheral has a control register at a base address and two alias addresses: one that sets every bit written as 1, and one that clears every bit written as 1. Two bits of that register matter here. The top bit is the soft-reset request. The bit below it is the clock-gate flag, which the peripheral raises on its own once a reset has taken hold.

After a one-cycle `start_i` pulse, the sequencer walks a fixed recovery order through a single-outstanding request/response port. The order is:

1. Release the soft reset and poll until it reads low.
2. Remove the clock gate.
3. Assert the soft reset and poll until the peripheral sets the clock gate.
4. Release the soft reset and poll until it reads low.
5. Remove the clock gate and poll until it reads low.

A settle delay of `SETTLE_CYCLES` idle cycles comes between each write that opens a poll and that poll's first read. Each poll is bounded to `POLL_LIMIT` reads. The run ends with a one-cycle `done_o`, and `error_o` is high in that same cycle if any poll ran out of reads.

The controller states are:

- IDLE: waiting for a start.
- WR_REQ: issue a write.
- WR_WAIT: await the write response.
- SETTLE: count the delay.
- RD_REQ: issue a read of the base address.
- RD_WAIT: await the read data and judge it.
- DONE: the one-cycle completion.

The transitions are:

- IDLE→WR_REQ on start.
- WR_REQ→WR_WAIT.
- WR_WAIT→SETTLE when the step polls.
- WR_WAIT→WR_REQ when the step does not poll.
- SETTLE→RD_REQ when the delay expires.
- RD_REQ→RD_WAIT.
- RD_WAIT→WR_REQ on a match with steps remaining.
- RD_WAIT→DONE on a match at the last step, or when the read budget runs out.
- RD_WAIT→RD_REQ on a miss with budget left.
- DONE→IDLE.

Top module: `rsq_top`

## Requirements
- R1: While reset is asserted and after it is released with no start, `req_valid_o`, `busy_o`, `done_o` and `error_o` are all 0.
- R2: A `start_i` pulse while idle raises `busy_o` in the following cycle and makes the first request a write.
- R3: Writes go out in this exact order, each with data holding only the named bit: clear alias (base+8) bit 31, clear alias bit 30, set alias (base+4) bit 31, clear alias bit 31, clear alias bit 30. Every read targets the base address.
- R4: `req_valid_o` is a one-cycle pulse, and no new request is issued until the previous one has received `rsp_valid_i`.
- R5: The first read of each poll is issued exactly `SETTLE_CYCLES`+1 cycles after the response of the write that opened it. The write that opens no poll (the second) is followed by the next write one cycle after its response.
- R6: Polls judge a single bit and ignore all others. The polls after the first and fourth writes end when bit 31 reads 0. The poll after the set write ends when bit 30 reads 1. The last poll ends when bit 30 reads 0. A miss with budget left triggers another read.
- R7: Each poll issues at most `POLL_LIMIT` reads. A match on the final allowed read still counts as success.
- R8: When a poll spends its budget without a match, `done_o` and `error_o` are high together for one cycle, one cycle after the last read response, and no further request is issued.
- R9: After the last poll matches, `done_o` is high for exactly one cycle with `error_o` low, one cycle after that read response.
- R10: `start_i` is ignored while a sequence is running. The run neither restarts nor gains extra requests or done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| req_valid_o | output | 1 | Register request strobe (one cycle) |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Target address (base, set alias or clear alias) |
| req_wdata_o | output | DATA_W | Write data (single bit set) |
| rsp_valid_i | input | 1 | Response for the outstanding request |
| rsp_rdata_i | input | DATA_W | Read data, valid with `rsp_valid_i` on reads |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Timeout flag, high only together with `done_o` |

## Verification
The bench builds the sequencer with `SETTLE_CYCLES`=4 and `POLL_LIMIT`=8. With these values the exact settle gap can be measured on every poll, and an exhausted read budget takes only a handful of reads, so a timeout can be forced in each of the four polls within a short run. The peripheral model answers with 1 to 3 cycles of latency and returns register values with unrelated bits set, so checking the wrong bit or the wrong level changes the read counts.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_SETTLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DONE
    } rsq_state_e;

    localparam int unsigned RSQ_STEPS  = 5;
    localparam int unsigned RSQ_STEP_W = $clog2(RSQ_STEPS);

    // One write plus an optional poll.
    typedef struct packed {
        logic via_set;    // 1: set alias, 0: clear alias
        logic on_srst;    // written bit: 1 soft reset (top), 0 clock gate
        logic polls;      // a poll follows this write
        logic poll_srst;  // polled bit: 1 soft reset, 0 clock gate
        logic poll_high;  // level that ends the poll
    } rsq_step_t;

    function automatic rsq_step_t rsq_step_info(input logic [RSQ_STEP_W-1:0] idx);
        rsq_step_t s;
        unique case (idx)
            3'd0:    s = '{via_set: 1'b0, on_srst: 1'b1, polls: 1'b1, poll_srst: 1'b1, poll_high: 1'b0};
            3'd1:    s = '{via_set: 1'b0, on_srst: 1'b0, polls: 1'b0, poll_srst: 1'b0, poll_high: 1'b0};
            3'd2:    s = '{via_set: 1'b1, on_srst: 1'b1, polls: 1'b1, poll_srst: 1'b0, poll_high: 1'b1};
            3'd3:    s = '{via_set: 1'b0, on_srst: 1'b1, polls: 1'b1, poll_srst: 1'b1, poll_high: 1'b0};
            3'd4:    s = '{via_set: 1'b0, on_srst: 1'b0, polls: 1'b1, poll_srst: 1'b0, poll_high: 1'b0};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rsq_step_decode.sv
module rsq_step_decode
    import rsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int unsigned SET_OFS = 4,
    parameter int unsigned CLR_OFS = 8
) (
    input  logic [RSQ_STEP_W-1:0] step_i,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [DATA_W-1:0]     wdata_o,
    output logic                  polls_o,
    output logic [DATA_W-1:0]     mask_o,
    output logic                  level_o,
    output logic                  last_o
);
    localparam int unsigned SRST_BIT = DATA_W - 1;
    localparam int unsigned GATE_BIT = DATA_W - 2;

    rsq_step_t info;

    always_comb begin
        info    = rsq_step_info(step_i);
        addr_o  = BASE_ADDR + (info.via_set ? ADDR_W'(SET_OFS) : ADDR_W'(CLR_OFS));
        polls_o = info.polls;
        level_o = info.poll_high;
        last_o  = (step_i == RSQ_STEP_W'(RSQ_STEPS - 1));
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == SRST_BIT) begin : g_srst
            assign wdata_o[b] = info.on_srst;
            assign mask_o[b]  = info.poll_srst;
        end else if (b == GATE_BIT) begin : g_gate
            assign wdata_o[b] = ~info.on_srst;
            assign mask_o[b]  = ~info.poll_srst;
        end else begin : g_zero
            assign wdata_o[b] = 1'b0;
            assign mask_o[b]  = 1'b0;
        end
    end

endmodule

// File: rtl/rsq_settle_timer.sv
module rsq_settle_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rsq_poll_budget.sv
module rsq_poll_budget #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bump_i,
    output logic final_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] miss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (clear_i) begin
            miss_q <= '0;
        end else if (bump_i) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    // High while the read in flight is the last one the poll may spend.
    assign final_o = (miss_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/rsq_top.sv
module rsq_top
    import rsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int unsigned SET_OFS = 4,
    parameter int unsigned CLR_OFS = 8,
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned POLL_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);
    rsq_state_e state_q, state_d;
    logic [RSQ_STEP_W-1:0] step_q, step_d;
    logic err_q, err_d;

    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_wdata;
    logic [DATA_W-1:0] step_mask;
    logic              step_polls;
    logic              step_level;
    logic              step_last;
    logic              rd_match;

    logic tmr_load, tmr_run, tmr_exp;
    logic cnt_clr, cnt_bump, cnt_final;

    rsq_step_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
        .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
    ) u_decode (
        .step_i (step_q),
        .addr_o (step_addr),
        .wdata_o(step_wdata),
        .polls_o(step_polls),
        .mask_o (step_mask),
        .level_o(step_level),
        .last_o (step_last)
    );

    rsq_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .run_i    (tmr_run),
        .expired_o(tmr_exp)
    );

    rsq_poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(cnt_clr),
        .bump_i (cnt_bump),
        .final_o(cnt_final)
    );

    assign rd_match = ((rsp_rdata_i & step_mask) != '0) == step_level;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            err_q   <= err_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        err_d    = err_q;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_bump = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_WR_REQ;
                    step_d  = '0;
                    err_d   = 1'b0;
                end
            end
            ST_WR_REQ: state_d = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (rsp_valid_i) begin
                    if (step_polls) begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (step_last) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_WR_REQ;
                        step_d  = step_q + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                tmr_run = 1'b1;
                if (tmr_exp) state_d = ST_RD_REQ;
            end
            ST_RD_REQ: state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rsp_valid_i) begin
                    if (rd_match) begin
                        if (step_last) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_WR_REQ;
                            step_d  = step_q + 1'b1;
                        end
                    end else if (cnt_final) begin
                        state_d = ST_DONE;
                        err_d   = 1'b1;
                    end else begin
                        state_d  = ST_RD_REQ;
                        cnt_bump = 1'b1;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid_o = 1'b0;
        req_write_o = 1'b0;
        req_addr_o  = BASE_ADDR;
        req_wdata_o = '0;
        busy_o      = (state_q != ST_IDLE);
        done_o      = 1'b0;
        error_o     = 1'b0;
        unique case (state_q)
            ST_WR_REQ: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b1;
                req_addr_o  = step_addr;
                req_wdata_o = step_wdata;
            end
            ST_RD_REQ: req_valid_o = 1'b1;
            ST_DONE: begin
                done_o  = 1'b1;
                error_o = err_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int unsigned POLL_LIMIT = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              req_valid_o,
    input logic              req_write_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DATA_W-1:0] req_wdata_o,
    input logic              rsp_valid_i,
    input logic [DATA_W-1:0] rsp_rdata_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o
);
    logic        outstanding_q;
    int unsigned reads_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
            reads_q       <= 0;
        end else begin
            if (req_valid_o)      outstanding_q <= 1'b1;
            else if (rsp_valid_i) outstanding_q <= 1'b0;
            if (req_valid_o && req_write_o)  reads_q <= 0;
            else if (req_valid_o)            reads_q <= reads_q + 1;
        end
    end

    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && req_valid_o && req_write_o)); // R2

    AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o) |-> ($countones(req_wdata_o) == 1)); // R3

    AST_READ_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_write_o) |-> (req_addr_o == BASE_ADDR)); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> !outstanding_q); // R4

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o); // R4

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_write_o) |-> (reads_q < POLL_LIMIT)); // R7

    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o); // R8

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !req_valid_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rsp_valid_i)); // R9

    AST_CLEAN_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> !$past(rsp_rdata_i[DATA_W-2])); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R10

endmodule

bind rsq_top rsq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .POLL_LIMIT(POLL_LIMIT)
) u_rsq_chk (.*);

// File: tb/rsq_top_tb.sv
`timescale 1ns/1ps
module rsq_top_tb;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int TB_SETTLE = 4;
    localparam int TB_LIMIT  = 8;
    localparam logic [31:0] TB_BASE = 32'h8002_0000;

    // {latency, fails poll0, poll1, poll2, poll3}; 8 fails = never matches
    localparam logic [19:0] VEC [8] = '{
        20'h1_0000, 20'h1_3102, 20'h1_7777, 20'h1_8000,
        20'h2_0800, 20'h1_0080, 20'h3_0008, 20'h3_2510
    };
    // Read values: miss values hold the wrong level on the judged bit, hit values the right one.
    localparam logic [31:0] MISSV [4] = '{32'hFFFF_FFFF, 32'hBFFF_FFFF, 32'h8000_0000, 32'h4000_0000};
    localparam logic [31:0] HITV  [4] = '{32'h7FFF_FFFF, 32'h4000_0000, 32'h4000_0001, 32'hBFFF_FFFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic req_valid_o, req_write_o;
    logic [AW-1:0] req_addr_o;
    logic [DW-1:0] req_wdata_o;
    logic rsp_valid_i = 1'b0;
    logic [DW-1:0] rsp_rdata_i = '0;
    logic busy_o, done_o, error_o;

    always #2.5 clk = ~clk;

    rsq_top #(
        .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(TB_BASE),
        .SETTLE_CYCLES(TB_SETTLE), .POLL_LIMIT(TB_LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_valid_o(req_valid_o), .req_write_o(req_write_o),
        .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
        .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral model and monitor
    int cyc = 0;
    int lat = 1;
    int fail_n [4];
    bit pend = 0;
    int pend_cnt = 0;
    bit pend_wr = 0;
    logic [31:0] pend_rdata = '0;
    int poll_idx = -1;
    int rd_cnt [4];
    int first_rd_cyc [4];
    int wr_cnt = 0;
    logic [31:0] wr_addr [8];
    logic [31:0] wr_data [8];
    int wr_req_cyc [8];
    int wr_rsp_cyc [8];
    int done_cnt = 0;
    logic err_at_done = 1'b0;
    int done_cyc = 0;
    int last_rsp_cyc = 0;
    int req_after_done = 0;
    int bad_rd_addr = 0;

    function automatic int poll_of_write(input int w);
        case (w)
            0: return 0;
            2: return 1;
            3: return 2;
            4: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int write_of_poll(input int p);
        case (p)
            0: return 0;
            1: return 2;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        rsp_valid_i = 1'b0;
        rsp_rdata_i = '0;
        if (pend) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                rsp_valid_i = 1'b1;
                rsp_rdata_i = pend_rdata;
                pend = 0;
                last_rsp_cyc = cyc;
                if (pend_wr && wr_cnt > 0 && wr_cnt <= 8) wr_rsp_cyc[wr_cnt-1] = cyc;
            end
        end
        if (done_o) begin
            done_cnt++;
            err_at_done = error_o;
            done_cyc = cyc;
        end
        if (req_valid_o) begin
            if (done_cnt > 0) req_after_done++;
            pend = 1;
            pend_cnt = lat;
            pend_wr = req_write_o;
            pend_rdata = '0;
            if (req_write_o) begin
                if (wr_cnt < 8) begin
                    wr_addr[wr_cnt] = req_addr_o;
                    wr_data[wr_cnt] = req_wdata_o;
                    wr_req_cyc[wr_cnt] = cyc;
                end
                poll_idx = poll_of_write(wr_cnt);
                wr_cnt++;
            end else begin
                if (req_addr_o != TB_BASE) bad_rd_addr++;
                if (poll_idx >= 0) begin
                    if (rd_cnt[poll_idx] == 0) first_rd_cyc[poll_idx] = cyc;
                    pend_rdata = (rd_cnt[poll_idx] < fail_n[poll_idx]) ? MISSV[poll_idx] : HITV[poll_idx];
                    rd_cnt[poll_idx]++;
                end
            end
        end
    end

    task automatic clear_log();
        pend = 0; pend_cnt = 0; poll_idx = -1; wr_cnt = 0; done_cnt = 0;
        err_at_done = 1'b0; req_after_done = 0; bad_rd_addr = 0;
        for (int k = 0; k < 4; k++) begin rd_cnt[k] = 0; first_rd_cyc[k] = 0; end
        for (int k = 0; k < 8; k++) begin wr_req_cyc[k] = 0; wr_rsp_cyc[k] = 0; end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
        repeat (8) @(negedge clk);
    endtask

    task automatic run_vec(input int idx, input logic [19:0] v);
        int tp = -1;
        int exp_wr;
        logic [31:0] exp_a [5];
        logic [31:0] exp_d [5];
        exp_a = '{TB_BASE + 8, TB_BASE + 8, TB_BASE + 4, TB_BASE + 8, TB_BASE + 8};
        exp_d = '{32'h8000_0000, 32'h4000_0000, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000};
        lat = int'(v[19:16]);
        fail_n[0] = int'(v[15:12]); fail_n[1] = int'(v[11:8]);
        fail_n[2] = int'(v[7:4]);   fail_n[3] = int'(v[3:0]);
        for (int k = 3; k >= 0; k--) if (fail_n[k] >= TB_LIMIT) tp = k;
        exp_wr = (tp < 0) ? 5 : write_of_poll(tp) + 1;
        clear_log();
        pulse_start();
        chk(busy_o == 1'b1, "R2", $sformatf("vec%0d busy after start", idx), busy_o, 1);
        wait_done();
        chk(done_cnt == 1, (tp < 0) ? "R9" : "R8", $sformatf("vec%0d done pulses", idx), done_cnt, 1);
        chk(err_at_done == (tp >= 0), (tp < 0) ? "R9" : "R8", $sformatf("vec%0d error", idx),
            err_at_done, (tp >= 0));
        chk(done_cyc - last_rsp_cyc == 1, (tp < 0) ? "R9" : "R8", $sformatf("vec%0d done delay", idx),
            done_cyc - last_rsp_cyc, 1);
        chk(req_after_done == 0, "R8", $sformatf("vec%0d requests after done", idx), req_after_done, 0);
        chk(wr_cnt == exp_wr, (tp < 0) ? "R3" : "R8", $sformatf("vec%0d write count", idx), wr_cnt, exp_wr);
        for (int w = 0; w < exp_wr && w < wr_cnt; w++) begin
            chk(wr_addr[w] == exp_a[w], "R3", $sformatf("vec%0d write%0d addr", idx, w), wr_addr[w], exp_a[w]);
            chk(wr_data[w] == exp_d[w], "R3", $sformatf("vec%0d write%0d data", idx, w), wr_data[w], exp_d[w]);
        end
        chk(bad_rd_addr == 0, "R3", $sformatf("vec%0d reads off base", idx), bad_rd_addr, 0);
        if (exp_wr >= 3)
            chk(wr_req_cyc[2] - wr_rsp_cyc[1] == 1, "R5", $sformatf("vec%0d chained write gap", idx),
                wr_req_cyc[2] - wr_rsp_cyc[1], 1);
        for (int k = 0; k < 4; k++) begin
            int exp_rd;
            if (tp >= 0 && k > tp) exp_rd = 0;
            else if (k == tp)      exp_rd = TB_LIMIT;
            else                   exp_rd = fail_n[k] + 1;
            chk(rd_cnt[k] == exp_rd, (k == tp) ? "R7" : "R6", $sformatf("vec%0d poll%0d reads", idx, k),
                rd_cnt[k], exp_rd);
            if (exp_rd > 0)
                chk(first_rd_cyc[k] - wr_rsp_cyc[write_of_poll(k)] == TB_SETTLE + 1, "R5",
                    $sformatf("vec%0d poll%0d settle gap", idx, k),
                    first_rd_cyc[k] - wr_rsp_cyc[write_of_poll(k)], TB_SETTLE + 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) fail_n[k] = 0;
        clear_log();
        // R1: outputs quiet while and after reset
        repeat (3) @(negedge clk);
        chk({req_valid_o, busy_o, done_o, error_o} == 4'b0, "R1", "outputs in reset",
            {req_valid_o, busy_o, done_o, error_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({req_valid_o, busy_o, done_o, error_o} == 4'b0, "R1", "idle after reset",
            {req_valid_o, busy_o, done_o, error_o}, 0);
        chk(wr_cnt == 0, "R1", "no requests without start", wr_cnt, 0);

        for (int i = 0; i < 8; i++) run_vec(i, VEC[i]);

        // R10: starts during a run are ignored
        lat = 2;
        for (int k = 0; k < 4; k++) fail_n[k] = 2;
        clear_log();
        pulse_start();
        repeat (10) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (15) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(wr_cnt == 5, "R10", "writes with extra starts", wr_cnt, 5);
        chk(done_cnt == 1, "R10", "done pulses with extra starts", done_cnt, 1);
        chk(err_at_done == 1'b0, "R10", "error with extra starts", err_at_done, 0);
        chk(rd_cnt[0] == 3, "R10", "poll0 reads with extra starts", rd_cnt[0], 3);

        // R1: reset in mid-run returns to idle
        lat = 1;
        for (int k = 0; k < 4; k++) fail_n[k] = 0;
        clear_log();
        pulse_start();
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({req_valid_o, busy_o, done_o, error_o} == 4'b0, "R1", "outputs after mid-run reset",
            {req_valid_o, busy_o, done_o, error_o}, 0);
        rst_n = 1'b1;
        clear_log();
        repeat (30) @(negedge clk);
        chk(wr_cnt == 0 && done_cnt == 0, "R1", "quiet after mid-run reset", wr_cnt + done_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule